// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block picks a link configuration for a display stream. It takes the sink's capability bytes, which are the maximum per-lane rate code and the maximum lane count, together with a requested pixel clock in kHz. From these it chooses the narrowest and slowest link that can carry the pixel clock. There are six candidate configurations: lane counts of 1, 2 and 4, each at a low per-lane rate (1.62 Gb/s) or a high per-lane rate (2.7 Gb/s). Each candidate carries a bandwidth threshold in kHz, and the thresholds rise in a fixed order.

The block is used as a one-shot calculator. The controller places the capability bytes and the pixel clock on the inputs and raises `start` for one cycle. On the next clock edge the block registers:
- the selected link clock (162000 or 270000 kHz, or 0),
- the lane count (1, 2, 4, or 0),
- a mode-valid flag.

It also raises `done` for that single cycle. The registered results then stay fixed until the next `start`. No data stream passes through the block, so every pin is a plain control or status pin and none has back-pressure.

Top module: `link_rate_lane_sel`

## Requirements
- R1: While reset is asserted and after it is released, with no start seen yet, `done`, `mode_ok`, `lane_cnt` and `link_khz` are all 0.
- R2: A cycle with `start` high at a rising edge makes `done` high after that edge for exactly one cycle. `done` is never high unless `start` was high at the previous edge.
- R3: When `start` is low, `lane_cnt`, `link_khz` and `mode_ok` keep their values, whatever the other inputs do.
- R4: The high per-lane rate is usable only when `max_rate_code` equals 8'h0a. Any other code, including 8'h06, removes every high-rate candidate, so `link_khz` is never 270000 for that request.
- R5: The lane limit is `max_lane_byte & 8'h1f`. A limit of 1 allows only the 1-lane candidates. A limit of 2 allows the 1- and 2-lane candidates. Any other limit, including 0, 3 and 4, allows all candidates. Bits 7..5 have no effect.
- R6: The candidates, in ascending order of threshold, are: 1 lane low (54000), 1 lane high (90000), 2 lanes low (108000), 2 lanes high (180000), 4 lanes low (216000) and 4 lanes high (360000). The chosen candidate is the first allowed one whose threshold is strictly greater than `pixel_khz`. A pixel clock equal to a threshold moves on to the next candidate.
- R7: A chosen candidate sets `lane_cnt` to its lane count (1, 2 or 4). It sets `link_khz` to 270000 if the candidate is high-rate and to 162000 if it is low-rate.
- R8: If no allowed candidate has a threshold above `pixel_khz`, then `lane_cnt` and `link_khz` are both 0 and `mode_ok` is 0.
- R9: `mode_ok` is 1 exactly when `lane_cnt` is nonzero. In that case `link_khz` is 162000 or 270000, and otherwise `link_khz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that requests a selection from the present inputs |
| max_rate_code | input | 8 | Sink maximum per-lane rate code (8'h0a selects the high rate) |
| max_lane_byte | input | 8 | Sink maximum lane count byte; only bits 4..0 are used |
| pixel_khz | input | PCLK_W (20) | Requested pixel clock in kHz |
| done | output | 1 | One-cycle pulse after a start |
| link_khz | output | 19 | Selected link clock in kHz: 162000, 270000 or 0 |
| lane_cnt | output | 3 | Selected lane count: 1, 2, 4 or 0 |
| mode_ok | output | 1 | The pixel clock fits within the sink's capability |

## Verification
The assertions make only two assumptions about the inputs:
- `start` is a plain per-cycle level and may be raised on back-to-back cycles.
- The capability bytes and the pixel clock matter only at the edge where `start` is high.

They assume nothing about the code values, so they still hold for unknown rate codes and for odd lane bytes. The stimulus stays within these assumptions: it changes every input only on the falling clock edge and holds `start` high for a single cycle per request. Between requests, the hold scenario deliberately changes the capability and clock inputs to show that the outputs ignore them.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // Fixed ladder shape: lane counts 1, 2, 4, each offered at a low and a high rate.
  localparam int unsigned LANE_STEPS = 3;
  localparam int unsigned ENTRIES    = 2 * LANE_STEPS;
  localparam int unsigned MAX_LANES  = 1 << (LANE_STEPS - 1);
  localparam int unsigned LANE_W     = $clog2(MAX_LANES + 1);
  localparam int unsigned RATE_W     = 19;
  localparam int unsigned CAP_W      = 8;

  localparam logic [CAP_W-1:0] CODE_HIGH_RATE = 8'h0a;
  localparam logic [CAP_W-1:0] LANE_FIELD     = 8'h1f;

  // Lane count carried by ladder position idx.
  function automatic int unsigned entry_lanes(input int unsigned idx);
    return 32'd1 << (idx / 2);
  endfunction

  // Odd positions run at the high per-lane rate.
  function automatic bit entry_is_high(input int unsigned idx);
    return (idx % 2) == 1;
  endfunction

  // Bandwidth threshold in kHz for ladder position idx.
  function automatic int unsigned entry_thresh(input int unsigned idx,
                                               input int unsigned low_khz,
                                               input int unsigned high_khz);
    return entry_lanes(idx) * (entry_is_high(idx) ? high_khz : low_khz);
  endfunction

  typedef struct packed {
    logic              ok;
    logic [LANE_W-1:0] lanes;
    logic [RATE_W-1:0] rate_khz;
  } pick_t;

endpackage

// File: rtl/lrs_cap_decode.sv
module lrs_cap_decode
  import lrs_pkg::*;
(
  input  logic [CAP_W-1:0]   rate_code,
  input  logic [CAP_W-1:0]   lane_byte,
  output logic [ENTRIES-1:0] allow
);

  logic        hi_ok;
  logic [31:0] cap_lanes;
  logic        limited;

  always_comb begin
    hi_ok     = (rate_code == CODE_HIGH_RATE);
    cap_lanes = 32'(lane_byte & LANE_FIELD);
    limited   = 1'b0;
    // Only an exact lane count below the widest step imposes a ceiling.
    for (int s = 0; s < int'(LANE_STEPS) - 1; s++) begin
      if (cap_lanes == (32'd1 << s)) limited = 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_allow
    localparam logic [31:0] LANES_G = 32'(entry_lanes(g));
    localparam bit          HIGH_G  = entry_is_high(g);
    assign allow[g] = (hi_ok || !HIGH_G) && (!limited || (LANES_G <= cap_lanes));
  end

endmodule

// File: rtl/lrs_thresh_cmp.sv
module lrs_thresh_cmp
  import lrs_pkg::*;
#(
  parameter int unsigned PCLK_W   = 20,
  parameter int unsigned LOW_KHZ  = 54000,
  parameter int unsigned HIGH_KHZ = 90000
) (
  input  logic [PCLK_W-1:0]  pixel_khz,
  output logic [ENTRIES-1:0] fits
);

  logic [31:0] pix_ext;
  assign pix_ext = 32'(pixel_khz);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    localparam logic [31:0] THR_G = 32'(entry_thresh(g, LOW_KHZ, HIGH_KHZ));
    assign fits[g] = THR_G > pix_ext;
  end

endmodule

// File: rtl/lrs_first_pick.sv
module lrs_first_pick
  import lrs_pkg::*;
#(
  parameter int unsigned LOW_RATE_KHZ  = 162000,
  parameter int unsigned HIGH_RATE_KHZ = 270000
) (
  input  logic [ENTRIES-1:0] cand,
  output pick_t              pick
);

  logic found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int unsigned i = 0; i < ENTRIES; i++) begin
      if (!found && cand[i]) begin
        found         = 1'b1;
        pick.ok       = 1'b1;
        pick.lanes    = LANE_W'(entry_lanes(i));
        pick.rate_khz = entry_is_high(i) ? RATE_W'(HIGH_RATE_KHZ) : RATE_W'(LOW_RATE_KHZ);
      end
    end
  end

endmodule

// File: rtl/lrs_result_reg.sv
module lrs_result_reg
  import lrs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  pick_t d,
  output logic  done,
  output pick_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      q    <= '0;
    end else begin
      done <= start;
      if (start) q <= d;
    end
  end

endmodule

// File: rtl/link_rate_lane_sel.sv
module link_rate_lane_sel
  import lrs_pkg::*;
#(
  parameter int unsigned PCLK_W        = 20,
  parameter int unsigned LOW_KHZ       = 54000,
  parameter int unsigned HIGH_KHZ      = 90000,
  parameter int unsigned LOW_RATE_KHZ  = 162000,
  parameter int unsigned HIGH_RATE_KHZ = 270000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        max_rate_code,
  input  logic [7:0]        max_lane_byte,
  input  logic [PCLK_W-1:0] pixel_khz,
  output logic              done,
  output logic [18:0]       link_khz,
  output logic [2:0]        lane_cnt,
  output logic              mode_ok
);

  logic [ENTRIES-1:0] allow;
  logic [ENTRIES-1:0] fits;
  pick_t              pick_d;
  pick_t              pick_q;

  lrs_cap_decode u_cap (
    .rate_code (max_rate_code),
    .lane_byte (max_lane_byte),
    .allow     (allow)
  );

  lrs_thresh_cmp #(
    .PCLK_W   (PCLK_W),
    .LOW_KHZ  (LOW_KHZ),
    .HIGH_KHZ (HIGH_KHZ)
  ) u_cmp (
    .pixel_khz (pixel_khz),
    .fits      (fits)
  );

  lrs_first_pick #(
    .LOW_RATE_KHZ  (LOW_RATE_KHZ),
    .HIGH_RATE_KHZ (HIGH_RATE_KHZ)
  ) u_pick (
    .cand (allow & fits),
    .pick (pick_d)
  );

  lrs_result_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .d     (pick_d),
    .done  (done),
    .q     (pick_q)
  );

  assign link_khz = pick_q.rate_khz;
  assign lane_cnt = pick_q.lanes;
  assign mode_ok  = pick_q.ok;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int unsigned PCLK_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        max_rate_code,
  input logic [7:0]        max_lane_byte,
  input logic [PCLK_W-1:0] pixel_khz,
  input logic              done,
  input logic [18:0]       link_khz,
  input logic [2:0]        lane_cnt,
  input logic              mode_ok
);

  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(link_khz) && $stable(lane_cnt) && $stable(mode_ok)));

  a_r4_no_high_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && max_rate_code != 8'h0a) |=> (link_khz != 19'd270000));

  a_r7_lane_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_cnt));

  a_r9_ok_matches_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok == (lane_cnt != 3'd0));

  a_r9_rate_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_cnt != 3'd0) ? (link_khz == 19'd162000 || link_khz == 19'd270000)
                       : (link_khz == 19'd0));

endmodule

bind link_rate_lane_sel lrs_checker #(.PCLK_W(PCLK_W)) u_lrs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .max_rate_code (max_rate_code),
  .max_lane_byte (max_lane_byte),
  .pixel_khz     (pixel_khz),
  .done          (done),
  .link_khz      (link_khz),
  .lane_cnt      (lane_cnt),
  .mode_ok       (mode_ok)
);

// File: tb/link_rate_lane_sel_bench.sv
module link_rate_lane_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PW         = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    max_rate_code = 8'h0;
  logic [7:0]    max_lane_byte = 8'h0;
  logic [PW-1:0] pixel_khz = '0;
  logic          done;
  logic [18:0]   link_khz;
  logic [2:0]    lane_cnt;
  logic          mode_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rate_lane_sel u_link_rate_lane_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .max_rate_code (max_rate_code),
    .max_lane_byte (max_lane_byte),
    .pixel_khz     (pixel_khz),
    .done          (done),
    .link_khz      (link_khz),
    .lane_cnt      (lane_cnt),
    .mode_ok       (mode_ok)
  );

  // Reference built from the requirement text: walk the ladder in order.
  function automatic void expect_sel(input logic [7:0] code, input logic [7:0] lb,
                                     input int pclk, output int lanes, output int rate);
    int thr [6] = '{54000, 90000, 108000, 180000, 216000, 360000};
    int cap = int'(lb & 8'h1f);
    int last = (cap == 1) ? 1 : (cap == 2) ? 3 : 5;
    lanes = 0;
    rate  = 0;
    for (int i = 0; i < 6; i++) begin
      if (code != 8'h0a && (i % 2) == 1) continue;
      if (i > last) return;
      if (thr[i] > pclk) begin
        lanes = (i < 2) ? 1 : (i < 4) ? 2 : 4;
        rate  = (i % 2) ? 270000 : 162000;
        return;
      end
    end
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One request: drive on falling edge, sample one falling edge later.
  task automatic request(input string req, input logic [7:0] code, input logic [7:0] lb,
                         input int pclk);
    int el, er;
    @(negedge clk);
    max_rate_code = code;
    max_lane_byte = lb;
    pixel_khz     = PW'(pclk);
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_sel(code, lb, pclk, el, er);
    check(req, "lanes", int'(lane_cnt), el);
    check(req, "rate", int'(link_khz), er);
    check(req, "mode_ok (R9)", int'(mode_ok), (el != 0) ? 1 : 0);
    check("R2", "done pulse", int'(done), 1);
    @(negedge clk);
    check("R2", "done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "lanes in reset", int'(lane_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "rate after reset", int'(link_khz), 0);
    check("R1", "mode_ok after reset", int'(mode_ok), 0);
  endtask

  task automatic t_full_cap();
    request("R7", 8'h0a, 8'h04, 50000);
    request("R7", 8'h0a, 8'h04, 100000);
    request("R7", 8'h0a, 8'h04, 300000);
    request("R7", 8'h0a, 8'h04, 200000);
  endtask

  task automatic t_boundaries();
    request("R6", 8'h0a, 8'h04, 54000);
    request("R6", 8'h0a, 8'h04, 53999);
    request("R6", 8'h0a, 8'h04, 180000);
    request("R6", 8'h0a, 8'h04, 359999);
  endtask

  task automatic t_low_rate();
    request("R4", 8'h06, 8'h04, 60000);
    request("R4", 8'h06, 8'h04, 200000);
    request("R4", 8'h14, 8'h04, 100000);
    request("R4", 8'h06, 8'h04, 215999);
  endtask

  task automatic t_lane_caps();
    request("R5", 8'h0a, 8'h81, 80000);
    request("R5", 8'h0a, 8'h22, 150000);
    request("R5", 8'h0a, 8'h03, 300000);
    request("R5", 8'h0a, 8'h00, 100000);
    request("R5", 8'h0a, 8'hE4, 250000);
  endtask

  task automatic t_too_high();
    request("R8", 8'h0a, 8'h04, 360000);
    request("R8", 8'h0a, 8'h01, 90000);
    request("R8", 8'h0a, 8'h02, 200000);
    request("R8", 8'h06, 8'h01, 60000);
    request("R8", 8'h06, 8'h04, 216000);
  endtask

  task automatic t_hold();
    request("R3", 8'h0a, 8'h04, 150000);
    @(negedge clk);
    max_rate_code = 8'h06;
    max_lane_byte = 8'h01;
    pixel_khz     = PW'(10000);
    repeat (3) @(negedge clk);
    check("R3", "lanes held", int'(lane_cnt), 2);
    check("R3", "rate held", int'(link_khz), 270000);
    check("R3", "mode_ok held", int'(mode_ok), 1);
    check("R2", "no done without start", int'(done), 0);
  endtask

  initial begin
    t_reset();
    t_full_cap();
    t_boundaries();
    t_low_rate();
    t_lane_caps();
    t_too_high();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule